// File: doc/BRIEF.md
# Prefetch-Aware Re-Reference Replacement for One Cache Set

This block holds the replacement state of a single set in a 16-way last-level cache. Each way carries a 2-bit re-reference prediction value (RRPV): 0 means the line is expected back immediately, 1 soon, 2 far off and 3 at a distant time. The cache's lookup logic presents one access at a time. Each access carries a hit flag, the hit way, a flag saying whether the request came from the prefetcher or from a demand load, and a 2-bit policy mode.

On a hit, the block promotes the way. On a miss, the block searches for a way at 3. If there is none, it ages the whole set by one step and searches again. When it finds a victim, it installs the incoming line there and pulses `done` with the victim index. Demand and prefetch requests can be handled differently at both points. One mode bit makes prefetch hits leave the line's state alone. The other mode bit places lines brought in by a prefetch miss at the distant level, so they are the first to leave.

Top module: `pa_rrip_ctrl`

## Requirements
- R1: Reset sets every way's RRPV to 3. While reset is held, and in the first cycle after it, `ready` is 1 and `done` is 0. The first miss after reset therefore selects way 0 after no aging pass.
- R2: On a miss the victim is the lowest-numbered way whose RRPV is 3.
- R3: If no way is at 3, each search cycle adds one to every RRPV. Each such pass costs one cycle, and at most 3 passes occur. `done` rises (1 + number of passes) cycles after the clock edge that accepted the miss.
- R4: A demand miss (`acc_pf`=0) installs the line at RRPV 2.
- R5: Modes are encoded 0 = baseline, 1 = hit-aware, 2 = miss-aware, 3 = both. A prefetch miss (`acc_pf`=1) installs the line at RRPV 3 in modes 2 and 3, and at RRPV 2 in modes 0 and 1.
- R6: A demand hit sets the hit way's RRPV to 0.
- R7: A prefetch hit leaves the hit way's RRPV unchanged in modes 1 and 3, and sets it to 0 in modes 0 and 2.
- R8: An access is taken only in a cycle where `ready` is 1. While a miss is being serviced, `ready` is 0 and any access presented is ignored: it changes no RRPV and produces no `done`.
- R9: Each accepted miss produces exactly one `done` pulse, one cycle wide, with `victim_way` holding the chosen way. A hit produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, taken when ready is 1 |
| acc_hit | input | 1 | 1 = the access hit in this set |
| acc_way | input | 4 | Way that hit (used only on hits) |
| acc_pf | input | 1 | 1 = prefetch request, 0 = demand |
| acc_mode | input | 2 | Policy mode: 0 baseline, 1 hit-aware, 2 miss-aware, 3 both |
| ready | output | 1 | Block is idle and can take an access |
| done | output | 1 | One-cycle pulse when a miss has been placed |
| victim_way | output | 4 | Way chosen for the miss, valid with done |

## Verification
Several properties are checked on every cycle:
- whenever a line is installed, the victim way holds the distant level;
- aging never starts while some way is already distant;
- the search never needs a fourth pass;
- `done` stays one cycle wide;
- a busy period only begins from an accepted miss;
- every way reads distant right after reset.

The scenarios are needed for the policy itself. Only they can show that each mode installs and promotes prefetch lines at the right level, that the lowest distant way wins, and that accesses presented while busy are dropped. These effects only become visible through the victim order and the latency of later misses.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    typedef enum logic [1:0] {
        MODE_BASE = 2'd0,
        MODE_HIT  = 2'd1,
        MODE_MISS = 2'd2,
        MODE_BOTH = 2'd3
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SRCH = 1'b1
    } state_e;

    typedef struct packed {
        logic  pf;
        mode_e mode;
    } miss_req_t;

    function automatic logic hit_aware(input mode_e m);
        return (m == MODE_HIT) || (m == MODE_BOTH);
    endfunction

    function automatic logic miss_aware(input mode_e m);
        return (m == MODE_MISS) || (m == MODE_BOTH);
    endfunction

endpackage

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel #(
    parameter int WAYS = 16,
    parameter int RW   = 2,
    localparam int WW  = $clog2(WAYS)
) (
    input  logic [WAYS*RW-1:0] rrpv_flat,
    output logic               found,
    output logic [WW-1:0]      way
);
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    logic [WAYS-1:0] distant;

    for (genvar g = 0; g < WAYS; g++) begin : g_dist
        assign distant[g] = (rrpv_flat[g*RW +: RW] == RMAX);
    end

    always_comb begin
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (distant[i]) way = WW'(i);
        end
    end

    assign found = |distant;

endmodule

// File: rtl/rrip_state_file.sv
module rrip_state_file #(
    parameter int WAYS = 16,
    parameter int RW   = 2,
    localparam int WW  = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit_we,
    input  logic [WW-1:0]      hit_way,
    input  logic               ins_we,
    input  logic [WW-1:0]      ins_way,
    input  logic [RW-1:0]      ins_val,
    input  logic               age_en,
    output logic [WAYS*RW-1:0] rrpv_flat
);
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    logic [RW-1:0] rr [WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) rr[i] <= RMAX;
        end else if (age_en) begin
            for (int i = 0; i < WAYS; i++) rr[i] <= rr[i] + 1'b1;
        end else begin
            if (ins_we) rr[ins_way] <= ins_val;
            if (hit_we) rr[hit_way] <= '0;
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_flat
        assign rrpv_flat[g*RW +: RW] = rr[g];
    end

    logic any_max;
    always_comb begin
        any_max = 1'b0;
        for (int i = 0; i < WAYS; i++) any_max = any_max | (rr[i] == RMAX);
    end

    // R3: aging is requested only when no way is distant, so no counter wraps
    a_r3_age_without_distant: assert property (@(posedge clk) disable iff (rst)
        age_en |-> !any_max);

    // R1: every way reads distant right after reset
    a_r1_reset_all_distant: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&rrpv_flat));

endmodule

// File: rtl/pa_rrip_ctrl.sv
module pa_rrip_ctrl
    import rrip_pkg::*;
#(
    parameter int WAYS = 16,
    parameter int RW   = 2,
    localparam int WW  = $clog2(WAYS),
    localparam int PW  = $clog2((1 << RW))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_hit,
    input  logic [WW-1:0] acc_way,
    input  logic          acc_pf,
    input  logic [1:0]    acc_mode,
    output logic          ready,
    output logic          done,
    output logic [WW-1:0] victim_way
);
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};
    localparam logic [PW-1:0] PMAX = PW'((1 << RW) - 1);

    state_e             state;
    miss_req_t          req;
    logic [PW-1:0]      pass_cnt;
    logic [WAYS*RW-1:0] rrpv_flat;
    logic               found;
    logic [WW-1:0]      sel_way;

    logic          accept, hit_we, ins_we, age_en;
    logic [RW-1:0] ins_val;
    mode_e         in_mode;

    assign in_mode = mode_e'(acc_mode);
    assign ready   = (state == ST_IDLE);
    assign accept  = acc_valid && ready;
    assign hit_we  = accept && acc_hit && !(acc_pf && hit_aware(in_mode));
    assign ins_we  = (state == ST_SRCH) && found;
    assign age_en  = (state == ST_SRCH) && !found;
    assign ins_val = (req.pf && miss_aware(req.mode)) ? RMAX : RMAX - 1'b1;

    rrip_state_file #(.WAYS(WAYS), .RW(RW)) u_state (
        .clk      (clk),
        .rst      (rst),
        .hit_we   (hit_we),
        .hit_way  (acc_way),
        .ins_we   (ins_we),
        .ins_way  (sel_way),
        .ins_val  (ins_val),
        .age_en   (age_en),
        .rrpv_flat(rrpv_flat)
    );

    rrip_victim_sel #(.WAYS(WAYS), .RW(RW)) u_sel (
        .rrpv_flat(rrpv_flat),
        .found    (found),
        .way      (sel_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req        <= '0;
            pass_cnt   <= '0;
            done       <= 1'b0;
            victim_way <= '0;
        end else begin
            done <= ins_we;
            unique case (state)
                ST_IDLE: begin
                    if (accept && !acc_hit) begin
                        state    <= ST_SRCH;
                        req.pf   <= acc_pf;
                        req.mode <= in_mode;
                        pass_cnt <= '0;
                    end
                end
                ST_SRCH: begin
                    if (found) begin
                        state      <= ST_IDLE;
                        victim_way <= sel_way;
                    end else begin
                        pass_cnt <= pass_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: after the last allowed pass a distant way must exist
    a_r3_pass_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRCH && pass_cnt == PMAX) |-> found);

    // R2: the way being filled is at the distant level when chosen
    a_r2_victim_distant: assert property (@(posedge clk) disable iff (rst)
        ins_we |-> (rrpv_flat[sel_way*RW +: RW] == RMAX));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a busy period only starts from an accepted miss
    a_r8_busy_from_miss: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(acc_valid && !acc_hit));

endmodule

// File: tb/sim_pa_rrip_ctrl.sv
module sim_pa_rrip_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_hit = 1'b0;
    logic [3:0] acc_way = '0;
    logic       acc_pf = 1'b0;
    logic [1:0] acc_mode = '0;
    logic       ready, done;
    logic [3:0] victim_way;

    pa_rrip_ctrl u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .acc_pf(acc_pf), .acc_mode(acc_mode),
        .ready(ready), .done(done), .victim_way(victim_way)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    finished = 0;

    // behavioural reference
    int m_rr [WAYS];
    bit m_busy = 0;
    int m_ins = 2;
    bit m_done = 0;
    int m_vic = 0;
    bit armed = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_rr[i]) m_rr[i] = 3;
            m_busy = 0; m_done = 0; armed = 1;
        end else begin
            m_done = 0;
            if (m_busy) begin
                int v;
                v = -1;
                for (int i = WAYS - 1; i >= 0; i--) if (m_rr[i] == 3) v = i;
                if (v >= 0) begin
                    m_rr[v] = m_ins; m_done = 1; m_vic = v; m_busy = 0;
                end else begin
                    foreach (m_rr[i]) m_rr[i] = m_rr[i] + 1;
                end
            end else if (acc_valid) begin
                if (acc_hit) begin
                    if (!(acc_pf && acc_mode[0])) m_rr[acc_way] = 0;
                end else begin
                    m_busy = 1;
                    m_ins = (acc_pf && acc_mode[1]) ? 3 : 2;
                end
            end
        end
    end

    task automatic check_int(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst && !finished) begin
            check_int(cur_tag, "ready vs model", int'(ready), int'(!m_busy));
            check_int(cur_tag, "done vs model", int'(done), int'(m_done));
            if (m_done) check_int(cur_tag, "victim vs model", int'(victim_way), m_vic);
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic hit(int way, bit pf, int mode);
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 4'(way);
        acc_pf = pf; acc_mode = 2'(mode);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic miss(string tag, bit pf, int mode, int exp_vic, int exp_lat, bit inject);
        int lat;
        @(negedge clk);
        acc_valid = 1'b1; acc_hit = 1'b0; acc_pf = pf; acc_mode = 2'(mode);
        @(posedge clk);
        @(negedge clk);
        if (inject) begin
            acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 4'd1; acc_pf = 1'b0;
        end else begin
            acc_valid = 1'b0;
        end
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        acc_valid = 1'b0;
        check_int(tag, "victim", int'(victim_way), exp_vic);
        check_int(tag, "latency", lat, exp_lat);
    endtask

    task automatic fill(int mode);
        for (int i = 0; i < WAYS; i++) miss("R2", 1'b0, mode, i, 1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        cur_tag = "R1";
        check_int("R1", "ready after reset", int'(ready), 1);
        check_int("R1", "done after reset", int'(done), 0);
        miss("R1", 1'b0, 0, 0, 1, 1'b0);

        // R3: all ways promoted to 0, three aging passes needed
        do_reset();
        cur_tag = "R6";
        for (int i = 0; i < WAYS; i++) hit(i, 1'b0, 0);
        cur_tag = "R3";
        miss("R3", 1'b0, 0, 0, 4, 1'b0);

        // R5: prefetch insertion per mode
        cur_tag = "R5";
        miss("R5", 1'b1, 0, 1, 1, 1'b0);
        miss("R5", 1'b1, 2, 2, 1, 1'b0);
        miss("R5", 1'b0, 2, 2, 1, 1'b0);
        miss("R5", 1'b1, 3, 3, 1, 1'b0);
        miss("R5", 1'b0, 3, 3, 1, 1'b0);
        miss("R5", 1'b1, 1, 4, 1, 1'b0);
        miss("R5", 1'b0, 1, 5, 1, 1'b0);

        // R7 in hit-aware mode, R6 demand promotion, R4 insertion at 2
        do_reset();
        cur_tag = "R4";
        fill(0);
        cur_tag = "R7";
        hit(0, 1'b1, 1);
        hit(1, 1'b0, 1);
        miss("R7", 1'b0, 1, 0, 2, 1'b0);
        miss("R6", 1'b0, 1, 2, 1, 1'b0);

        // R7 baseline: prefetch hit promotes
        do_reset();
        fill(0);
        hit(0, 1'b1, 0);
        miss("R7", 1'b0, 0, 1, 2, 1'b0);

        // R7 both-aware mode
        do_reset();
        fill(3);
        hit(0, 1'b1, 3);
        hit(1, 1'b0, 3);
        miss("R7", 1'b0, 3, 0, 2, 1'b0);

        // R8: accesses presented while busy are dropped
        do_reset();
        cur_tag = "R8";
        for (int i = 0; i < WAYS; i++) hit(i, 1'b0, 0);
        miss("R8", 1'b0, 0, 0, 4, 1'b1);
        miss("R8", 1'b0, 0, 1, 1, 1'b0);

        // R9: no done from a hit
        cur_tag = "R9";
        hit(3, 1'b0, 0);
        repeat (3) @(negedge clk);
        check_int("R9", "done idle after hit", int'(done), 0);

        finish_up();
    end
endmodule